// File: doc/BRIEF.md
# LIN Master Receive-Frame Sequencer

This block is the master side of a LIN bus for one receive frame. Software, or any upstream engine, pushes a four-byte command record through a byte-wide valid/ready port. The record gives the frame identifier, the number of response bytes, the checksum options, a direction bit and a 12-bit response timeout. The block sends the header on its serial TX output: a break, the sync byte and the protected identifier. It then listens on the serial RX input for the slave's response and checksum, and passes each received data byte downstream on a byte-wide valid/ready port.

Both serial shifters run from one sample tick. The tick comes from a programmable clock divisor, and each bit lasts sixteen ticks. The receiver decides each bit by a two-of-three vote. When the frame ends, the block raises a done flag and reports a checksum mismatch or an expired response timeout. These flags hold until the next record starts.

Top module: `lin_rx_sequencer`

## Requirements
- R1: After reset, `lin_tx` is 1, `cmd_ready` is 1, `rsp_valid`, `done`, `cksum_err` and `timeout_err` are 0. `cmd_ready` is 0 while a frame is running.
- R2: After the fourth record byte, `lin_tx` stays 0 for 13 bit times, then 1 for one bit time, then carries byte 0x55. Every byte uses one 0 start bit, eight data bits sent LSB first and one 1 stop bit.
- R3: The third byte on `lin_tx` is {P1,P0,ID[5:0]}, with P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). ID comes from record byte 0 bits [5:0]. Bits [7:6] of byte 0 are ignored.
- R4: Record byte 1 is LEN. The first LEN bytes received after the identifier appear on `rsp_data`/`rsp_valid` in arrival order. The byte after them is taken as the checksum.
- R5: With record byte 2 bit 7 (checksum enable) set, `cksum_err` is set when the checksum byte is not the inverted 8-bit end-around-carry sum of the LEN data bytes (0xFF when LEN is 0).
- R6: With record byte 2 bit 7 clear, no checksum comparison is made and `cksum_err` stays 0.
- R7: With record byte 2 bit 6 set, the checksum byte is also forwarded on `rsp_data` after the data bytes. With this bit clear, it is not forwarded.
- R8: The timeout is TO[11:8] = byte 2 bits [3:0] and TO[7:0] = byte 3, counted in bit times from the end of the identifier's stop bit. If the checksum byte has not arrived when the count reaches TO, `timeout_err` and `done` are set, reception stops and no further bytes are forwarded.
- R9: A record with byte 2 bit 5 (direction) set is discarded. `lin_tx` stays 1, `done` stays 0 and `cmd_ready` stays 1.
- R10: One bit lasts 16 × (`baud_div` + 1) clock cycles.
- R11: Each received bit is the majority of samples 7, 8 and 9 of its sixteen. A one-sample disturbance in mid-bit does not change the received byte.
- R12: `done` is set when a frame finishes. `done`, `cksum_err` and `timeout_err` hold until a record byte is accepted, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Sample-tick divisor, tick every baud_div+1 clocks |
| cmd_data | input | 8 | Command record byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Block accepts a command byte |
| lin_tx | output | 1 | Serial transmit line, idle 1 |
| lin_rx | input | 1 | Serial receive line, idle 1 |
| rsp_data | output | 8 | Received response byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Downstream takes the byte |
| done | output | 1 | Frame finished |
| cksum_err | output | 1 | Checksum mismatch in last frame |
| timeout_err | output | 1 | Response timeout in last frame |

## Verification
The bench sweeps all 64 identifiers. Half of them carry deliberately wrong parity bits, which separates computed parity from copied parity. Payload lengths run from 0 to 4 and the checksum options change from frame to frame. Some checksum bytes are corrupted with checking on and some with checking off, which separates R5 from R6. Separate frames check a slower divisor, single-sample glitches in mid-bit, an expired timeout that must leave the stream empty, and a discarded transmit-direction record.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;
  typedef enum logic [2:0] {S_CMD, S_BRK, S_SYN, S_PID, S_RSP} seq_st_t;

  function automatic logic [7:0] prot_id(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_seq_tick.sv
module lin_seq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, cnt_n;

  assign tick = (cnt == '0);

  always_comb begin
    if (tick) cnt_n = div;
    else      cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;

  // R10: ticks are at least two clocks apart when the divisor is non-zero
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/lin_seq_tx.sv
module lin_seq_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       brk,
  input  logic [7:0] byte_i,
  output logic       line,
  output logic       busy,
  output logic       done
);
  localparam int SW = $clog2(OVS);

  logic [13:0]   sh, sh_n;
  logic [3:0]    left, left_n;
  logic [SW-1:0] scnt, scnt_n;
  logic          busy_n, done_n;

  assign line = busy ? sh[0] : 1'b1;

  always_comb begin
    sh_n = sh; left_n = left; scnt_n = scnt; busy_n = busy; done_n = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      scnt_n = '0;
      if (brk) begin sh_n = {1'b1, 13'd0};                left_n = 4'd14; end
      else     begin sh_n = {4'hF, 1'b1, byte_i, 1'b0};   left_n = 4'd10; end
    end else if (busy && tick) begin
      if (scnt == SW'(OVS-1)) begin
        scnt_n = '0;
        sh_n   = {1'b1, sh[13:1]};
        left_n = left - 1'b1;
        if (left == 4'd1) begin busy_n = 1'b0; done_n = 1'b1; end
      end else begin
        scnt_n = scnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '1; left <= '0; scnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      sh <= sh_n; left <= left_n; scnt <= scnt_n; busy <= busy_n; done <= done_n;
    end

  // R2: a finished shift always leaves the line released
  p_tx_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> line);
endmodule

// File: rtl/lin_seq_rx.sv
module lin_seq_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       rx_i,
  output logic       valid,
  output logic [7:0] byte_o
);
  localparam int SW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic [1:0]    sync, sh, sh_n;
  logic          rx_s, act, act_n, valid_n, maj;
  logic [SW-1:0] scnt, scnt_n;
  logic [3:0]    bidx, bidx_n;
  logic [7:0]    data_n;

  assign rx_s = sync[1];
  assign maj  = (sh[1] & sh[0]) | (sh[1] & rx_s) | (sh[0] & rx_s);

  always_comb begin
    sh_n = sh; act_n = act; scnt_n = scnt; bidx_n = bidx; data_n = byte_o; valid_n = 1'b0;
    if (!en) begin
      act_n = 1'b0;
    end else if (tick) begin
      sh_n = {sh[0], rx_s};
      if (!act) begin
        if (!rx_s) begin act_n = 1'b1; scnt_n = SW'(1); bidx_n = '0; end
      end else begin
        if (scnt == SW'(OVS-1)) begin scnt_n = '0; bidx_n = bidx + 1'b1; end
        else                          scnt_n = scnt + 1'b1;
        if (scnt == SW'(MID+1)) begin
          if (bidx == 4'd0)      begin if (maj) act_n = 1'b0; end
          else if (bidx == 4'd9) begin valid_n = 1'b1; act_n = 1'b0; end
          else                   data_n = {maj, byte_o[7:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync <= 2'b11; sh <= 2'b11; act <= 1'b0; scnt <= '0; bidx <= '0;
      byte_o <= '0; valid <= 1'b0;
    end else begin
      sync <= {sync[0], rx_i}; sh <= sh_n; act <= act_n; scnt <= scnt_n;
      bidx <= bidx_n; byte_o <= data_n; valid <= valid_n;
    end

  // R11: a byte completes at most once per character time, never back to back
  p_rx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/lin_rx_sequencer.sv
module lin_rx_sequencer
  import lin_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  output logic             lin_tx,
  input  logic             lin_rx,
  output logic [7:0]       rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             done,
  output logic             cksum_err,
  output logic             timeout_err
);
  localparam int SW = $clog2(OVS);

  seq_st_t       st, st_n;
  logic [1:0]    idx, idx_n;
  logic [5:0]    id, id_n;
  logic [7:0]    len, len_n, rcnt, rcnt_n, acc, acc_n, od_n;
  logic          cse, cse_n, crc, crc_n, td, td_n;
  logic [11:0]   to, to_n, bitcnt, bitcnt_n;
  logic [SW-1:0] bsamp, bsamp_n;
  logic          launch, launch_n, ov_n, done_n, cke_n, toe_n;
  logic          tick, tx_busy, tx_done, rx_valid;
  logic [7:0]    rx_byte;

  lin_seq_tick #(.DIV_W(DIV_W)) u_tick (.clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick));

  lin_seq_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(launch), .brk(st == S_BRK),
    .byte_i((st == S_SYN) ? 8'h55 : prot_id(id)),
    .line(lin_tx), .busy(tx_busy), .done(tx_done));

  lin_seq_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(st == S_RSP), .rx_i(lin_rx),
    .valid(rx_valid), .byte_o(rx_byte));

  assign cmd_ready = (st == S_CMD);

  always_comb begin
    st_n = st; idx_n = idx; id_n = id; len_n = len; cse_n = cse; crc_n = crc; td_n = td;
    to_n = to; rcnt_n = rcnt; acc_n = acc; bitcnt_n = bitcnt; bsamp_n = bsamp;
    launch_n = 1'b0; ov_n = rsp_valid; od_n = rsp_data;
    done_n = done; cke_n = cksum_err; toe_n = timeout_err;
    if (rsp_valid && rsp_ready) ov_n = 1'b0;
    case (st)
      S_CMD: if (cmd_valid) begin
        done_n = 1'b0; cke_n = 1'b0; toe_n = 1'b0;
        idx_n  = idx + 1'b1;
        case (idx)
          2'd0: id_n  = cmd_data[5:0];
          2'd1: len_n = cmd_data;
          2'd2: begin cse_n = cmd_data[7]; crc_n = cmd_data[6]; td_n = cmd_data[5];
                      to_n[11:8] = cmd_data[3:0]; end
          default: begin
            to_n[7:0] = cmd_data;
            if (!td) begin st_n = S_BRK; launch_n = 1'b1; end
          end
        endcase
      end
      S_BRK: if (tx_done) begin st_n = S_SYN; launch_n = 1'b1; end
      S_SYN: if (tx_done) begin st_n = S_PID; launch_n = 1'b1; end
      S_PID: if (tx_done) begin
        st_n = S_RSP; rcnt_n = '0; acc_n = '0; bitcnt_n = '0; bsamp_n = '0;
      end
      default: begin
        if (tick) begin
          bsamp_n = bsamp + 1'b1;
          if (bsamp == SW'(OVS-1)) bitcnt_n = bitcnt + 1'b1;
        end
        if (rx_valid) begin
          if (rcnt != len) begin
            acc_n = cks_add(acc, rx_byte); rcnt_n = rcnt + 1'b1;
            ov_n = 1'b1; od_n = rx_byte;
          end else begin
            if (cse && (rx_byte != ~acc)) cke_n = 1'b1;
            if (crc) begin ov_n = 1'b1; od_n = rx_byte; end
            done_n = 1'b1; st_n = S_CMD;
          end
        end else if (bitcnt == to) begin
          toe_n = 1'b1; done_n = 1'b1; st_n = S_CMD;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_CMD; idx <= '0; id <= '0; len <= '0; cse <= 1'b0; crc <= 1'b0; td <= 1'b0;
      to <= '0; rcnt <= '0; acc <= '0; bitcnt <= '0; bsamp <= '0; launch <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0; done <= 1'b0; cksum_err <= 1'b0; timeout_err <= 1'b0;
    end else begin
      st <= st_n; idx <= idx_n; id <= id_n; len <= len_n; cse <= cse_n; crc <= crc_n; td <= td_n;
      to <= to_n; rcnt <= rcnt_n; acc <= acc_n; bitcnt <= bitcnt_n; bsamp <= bsamp_n;
      launch <= launch_n; rsp_valid <= ov_n; rsp_data <= od_n;
      done <= done_n; cksum_err <= cke_n; timeout_err <= toe_n;
    end

  // R12: an accepted record byte clears all completion flags
  p_flags_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!done && !cksum_err && !timeout_err));
  // R12: a finished frame leaves the block ready for the next record
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  // R8: a frame ends either by timeout or by checksum arrival, never both
  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cksum_err && timeout_err));
  // R9: with no frame running and the shifter idle, the bus is released
  p_tx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !tx_busy) |-> lin_tx);
endmodule

// File: tb/tb_lin_rx_sequencer.sv
`timescale 1ns/1ps
module tb_lin_rx_sequencer;
  localparam int CLK_PER = 10;
  localparam int OVS     = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] baud_div = '0, cmd_data = '0, rsp_data;
  logic cmd_valid = 1'b0, cmd_ready, lin_tx, lin_rx, rsp_valid, rsp_ready = 1'b1;
  logic done, cksum_err, timeout_err, slv = 1'b1;
  int n_chk = 0, n_bad = 0, got_n = 0, bp = OVS;
  logic [7:0] got [0:31];

  assign lin_rx = lin_tx & slv;
  always #(CLK_PER/2) clk = ~clk;

  lin_rx_sequencer dut (.clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cmd_data(cmd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .lin_tx(lin_tx), .lin_rx(lin_rx),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .done(done),
    .cksum_err(cksum_err), .timeout_err(timeout_err));

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (got_n < 32) got[got_n] = rsp_data;
    got_n = got_n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pid(input logic [5:0] id);
    return {~(id[1]^id[3]^id[4]^id[5]), id[0]^id[1]^id[2]^id[4], id};
  endfunction

  function automatic logic [7:0] ref_add(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 255) s = s - 255;
    return 8'(s);
  endfunction

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_data = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic read_tx(output logic [7:0] b);
    @(negedge lin_tx);
    repeat (bp/2) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      repeat (bp) @(posedge clk); #1 b[k] = lin_tx;
    end
    repeat (bp) @(posedge clk);
  endtask

  task automatic slave_byte(input logic [7:0] b, input bit glitch);
    @(posedge clk); #1 slv = 1'b0;
    repeat (bp) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      #1 slv = b[k];
      if (glitch) begin
        repeat (bp/2) @(posedge clk); #1 slv = ~b[k];
        @(posedge clk); #1 slv = b[k];
        repeat (bp/2 - 1) @(posedge clk);
      end else repeat (bp) @(posedge clk);
    end
    #1 slv = 1'b1;
    repeat (bp) @(posedge clk);
  endtask

  task automatic frame(input int div, input logic [5:0] id, input bit badp, input int len,
                       input bit cse, input bit crc, input logic [11:0] to,
                       input bit corrupt, input bit glitch, input bit to_case, input string rq);
    logic [7:0] pid, syn, rpid, acc, cks;
    logic [7:0] dat [0:7];
    int blen, nexp;
    bit ok;
    baud_div = 8'(div); bp = OVS * (div + 1); got_n = 0;
    pid = ref_pid(id);
    fork
      begin
        send_cmd({badp ? ~pid[7:6] : pid[7:6], id});
        send_cmd(8'(len));
        send_cmd({cse, crc, 2'b00, to[11:8]});
        send_cmd(to[7:0]);
      end
      begin
        @(negedge lin_tx); blen = 0;
        while (lin_tx == 1'b0) begin @(posedge clk); #1 blen++; end
        read_tx(syn);
        read_tx(rpid);
      end
    join
    check(blen >= 13*bp - div - 1 && blen <= 13*bp + div + 1, "R2 break length", blen, 13*bp);
    check(syn == 8'h55, {"R2 sync ", rq}, syn, 8'h55);
    check(rpid == pid, "R3 protected id", rpid, pid);
    check(cmd_ready == 1'b0, "R1 busy during frame", cmd_ready, 0);
    acc = 8'h00;
    for (int k = 0; k < len; k++) begin
      dat[k] = 8'(id * 37 + k * 11 + 3);
      acc = ref_add(acc, dat[k]);
    end
    cks = ~acc;
    if (corrupt) cks = cks ^ 8'h5A;
    repeat (2*bp) @(posedge clk);
    for (int k = 0; k < len; k++) slave_byte(dat[k], glitch);
    slave_byte(cks, 1'b0);
    repeat (4) @(posedge clk); #1;
    if (to_case) begin
      check(got_n == 0, "R8 no bytes after timeout", got_n, 0);
      check(timeout_err == 1'b1 && done == 1'b1, "R8 timeout flag", {done, timeout_err}, 3);
      check(cksum_err == 1'b0, "R8 no checksum flag", cksum_err, 0);
    end else begin
      nexp = len + (crc ? 1 : 0);
      check(got_n == nexp, crc ? "R7 forwarded count" : "R4 forwarded count", got_n, nexp);
      ok = 1'b1;
      for (int k = 0; k < len && k < got_n; k++) if (got[k] != dat[k]) ok = 1'b0;
      check(ok, {"R4 data order ", rq}, got_n > 0 ? got[0] : 0, len > 0 ? dat[0] : 0);
      if (crc && got_n == nexp) check(got[len] == cks, "R7 checksum forwarded", got[len], cks);
      check(cksum_err == (cse && corrupt), cse ? "R5 checksum flag" : "R6 checksum ignored",
            cksum_err, cse && corrupt);
      check(done == 1'b1 && timeout_err == 1'b0, "R12 done set", {done, timeout_err}, 2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(lin_tx == 1'b1 && cmd_ready == 1'b1, "R1 reset lines", {lin_tx, cmd_ready}, 3);
    check(!rsp_valid && !done && !cksum_err && !timeout_err, "R1 reset flags",
          {rsp_valid, done, cksum_err, timeout_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 64; i++)
      frame(0, 6'(i), i[0], i % 5, (i % 7) != 3, (i % 3) == 0, 12'h0FF,
            (i % 9) == 4 || i == 3 || i == 10, (i % 8) == 5, 1'b0,
            (i % 8) == 5 ? "R11 glitch" : "sweep");
    frame(2, 6'h3C, 1'b0, 3, 1'b1, 1'b0, 12'h0FF, 1'b0, 1'b0, 1'b0, "R10 div2");
    frame(0, 6'h11, 1'b0, 2, 1'b1, 1'b0, 12'h005, 1'b0, 1'b0, 1'b1, "R8");
    send_cmd(8'h22);
    #1 check(done == 1'b0 && timeout_err == 1'b0, "R12 flags cleared", {done, timeout_err}, 0);
    send_cmd(8'h01); send_cmd(8'hA0); send_cmd(8'h40);
    begin
      int lows;
      lows = 0;
      repeat (30*OVS) begin @(posedge clk); #1 if (!lin_tx) lows++; end
      check(lows == 0, "R9 no header", lows, 0);
      check(cmd_ready == 1'b1 && done == 1'b0, "R9 record discarded", {cmd_ready, done}, 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule